// File: doc/BRIEF.md
# Register Pair Transfer Sequencer

This controller turns one paired load or paired store into two memory beats, one after the other, on a plain request/acknowledge memory port. A command gives a base address, a signed immediate, an addressing mode, an element width (32 or 64 bits), a direction, two register indices and, for stores, the two data words. The sequencer works out the first effective address, issues the beat for the first register, then issues the beat for the second register one element higher. It returns each loaded word together with its destination index as that beat is acknowledged.

For the two indexed modes the updated base is reported once, after both beats have finished. When the command names the stack pointer as its base, the base must be 16-byte aligned. A misaligned stack base ends the command with a fault and no memory traffic. The register file, decode and caches sit outside this block.

Top module: `pair_xfer_seq`

## Requirements
- R1: A command is taken when `cmd_valid` is high and `busy` is low. `busy` rises on the next cycle and stays high through the cycle in which `done` is high. Commands presented while `busy` is high are ignored.
- R2: The first beat carries the first register: its index on loads and `cmd_wdata0` on stores. It goes to the first effective address.
- R3: The second beat follows the first and carries the second register. Its address is the first address plus 4 when `cmd_wide`=0, or plus 8 when `cmd_wide`=1.
- R4: With `cmd_mode`=0 (signed offset; the value 3 behaves the same), the first address is base + immediate × element bytes, and no writeback is reported.
- R5: With `cmd_mode`=1 (pre-index), both beats use base + immediate in bytes, and base + immediate is written back.
- R6: With `cmd_mode`=2 (post-index), the beats start at the unmodified base, and base + immediate in bytes is written back.
- R7: While `mem_req` is high and `mem_ack` is low, the request, address, write enable and write data hold steady into the next cycle.
- R8: `wb_valid` pulses for exactly one cycle per indexed command, after the second beat has been acknowledged and before `done`. It carries `wb_addr`.
- R9: If `cmd_sp_base`=1 and `cmd_base[3:0]` is nonzero, no beat is issued, no writeback occurs, and `fault` is high in the `done` cycle. `fault` is low in every other `done` cycle.
- R10: On each acknowledged load beat, `ld_valid` is high in that same cycle, with `ld_idx` set to the beat's register and `ld_data` equal to `mem_rdata`. Store beats drive `mem_we`=1 and never raise `ld_valid`.
- R11: `done` is a one-cycle pulse. The sequencer is idle in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_mode | input | 2 | 0 signed offset, 1 pre-index, 2 post-index |
| cmd_wide | input | 1 | 1 = 64-bit elements, 0 = 32-bit |
| cmd_store | input | 1 | 1 = store pair, 0 = load pair |
| cmd_sp_base | input | 1 | Base register is the stack pointer |
| cmd_base | input | AW | Base address |
| cmd_imm | input | IW | Signed immediate |
| cmd_rt0 | input | RW | First register index |
| cmd_rt1 | input | RW | Second register index |
| cmd_wdata0 | input | DW | Store data for the first register |
| cmd_wdata1 | input | DW | Store data for the second register |
| busy | output | 1 | Command in progress |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_wide | output | 1 | Beat is 64 bits wide |
| mem_addr | output | AW | Beat byte address |
| mem_wdata | output | DW | Beat write data |
| mem_ack | input | 1 | Memory accepts the beat |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| ld_valid | output | 1 | Load result valid |
| ld_idx | output | RW | Destination register of the result |
| ld_data | output | DW | Loaded word |
| wb_valid | output | 1 | Base writeback strobe |
| wb_addr | output | AW | New base value |
| done | output | 1 | Command finished |
| fault | output | 1 | Alignment fault, valid with `done` |

## Verification
The bench uses the default parameters: a 16-bit address, 64-bit data, a 7-bit immediate and 5-bit register indices. This keeps every address computation easy to predict, including wrap below zero. With that configuration it sweeps every mode, both widths, both directions, negative and positive immediates, and acknowledge latencies from zero to two cycles. That covers same-cycle acknowledges as well as held requests. Separate cases hold a conflicting command on the inputs while the sequencer is busy, and cover a stack-pointer base that is aligned and one that is misaligned.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

    typedef enum logic [1:0] {
        AM_OFFSET = 2'd0,
        AM_PRE    = 2'd1,
        AM_POST   = 2'd2,
        AM_RSVD   = 2'd3
    } amode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_BEAT0,
        S_BEAT1,
        S_WB,
        S_DONE
    } seq_state_e;

    localparam int SP_ALIGN_BITS = 4;

    function automatic int unsigned elem_shift(input logic wide);
        return wide ? 3 : 2;
    endfunction

    function automatic logic mode_writes_back(input amode_e m);
        return (m == AM_PRE) || (m == AM_POST);
    endfunction

endpackage

// File: rtl/pxs_addr_gen.sv
module pxs_addr_gen
    import pxs_pkg::*;
#(
    parameter int AW = 16,
    parameter int IW = 7
) (
    input  logic [AW-1:0] base,
    input  logic [IW-1:0] imm,
    input  amode_e        mode,
    input  logic          wide,
    output logic [AW-1:0] ea0,
    output logic [AW-1:0] wb_addr
);
    logic [AW-1:0] imm_x;
    logic [AW-1:0] imm_scaled;

    assign imm_x      = {{(AW-IW){imm[IW-1]}}, imm};
    assign imm_scaled = imm_x << elem_shift(wide);

    always_comb begin
        case (mode)
            AM_PRE:  ea0 = base + imm_x;
            AM_POST: ea0 = base;
            default: ea0 = base + imm_scaled;
        endcase
    end

    assign wb_addr = base + imm_x;

endmodule

// File: rtl/pxs_beat_ctrl.sv
module pxs_beat_ctrl
    import pxs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    input  logic has_wb,
    input  logic mem_ack,
    output logic mem_req,
    output logic beat_sel,
    output logic busy,
    output logic wb_valid,
    output logic done
);
    seq_state_e state;
    logic [1:0] beats_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
        end else begin
            case (state)
                S_IDLE:  if (start) state <= abort ? S_DONE : S_BEAT0;
                S_BEAT0: if (mem_ack) state <= S_BEAT1;
                S_BEAT1: if (mem_ack) state <= has_wb ? S_WB : S_DONE;
                S_WB:    state <= S_DONE;
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                  beats_seen <= 2'd0;
        else if (start)           beats_seen <= 2'd0;
        else if (mem_req && mem_ack) beats_seen <= beats_seen + 2'd1;
    end

    assign mem_req  = (state == S_BEAT0) || (state == S_BEAT1);
    assign beat_sel = (state == S_BEAT1);
    assign busy     = (state != S_IDLE);
    assign wb_valid = (state == S_WB);
    assign done     = (state == S_DONE);

    p_wb_after_pair_r8: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (beats_seen == 2'd2));

    p_wb_single_r8: assert property (@(posedge clk) disable iff (rst)
        wb_valid |=> !wb_valid);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    p_busy_rise_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

endmodule

// File: rtl/pair_xfer_seq.sv
module pair_xfer_seq
    import pxs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 64,
    parameter int IW = 7,
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_mode,
    input  logic          cmd_wide,
    input  logic          cmd_store,
    input  logic          cmd_sp_base,
    input  logic [AW-1:0] cmd_base,
    input  logic [IW-1:0] cmd_imm,
    input  logic [RW-1:0] cmd_rt0,
    input  logic [RW-1:0] cmd_rt1,
    input  logic [DW-1:0] cmd_wdata0,
    input  logic [DW-1:0] cmd_wdata1,
    output logic          busy,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_wide,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          ld_valid,
    output logic [RW-1:0] ld_idx,
    output logic [DW-1:0] ld_data,
    output logic          wb_valid,
    output logic [AW-1:0] wb_addr,
    output logic          done,
    output logic          fault
);
    localparam logic [AW-1:0] STEP_NARROW = AW'(4);
    localparam logic [AW-1:0] STEP_WIDE   = AW'(8);

    amode_e        mode_in;
    logic          accept;
    logic          misaligned;
    logic [AW-1:0] ea0_c, wb_c;
    logic          beat_sel;

    logic [AW-1:0] ea0_q, wb_q;
    logic          wide_q, store_q, fault_q, has_wb_q;
    logic [RW-1:0] rt0_q, rt1_q;
    logic [DW-1:0] wd0_q, wd1_q;

    assign mode_in    = amode_e'(cmd_mode);
    assign accept     = cmd_valid && !busy;
    assign misaligned = cmd_sp_base && (cmd_base[SP_ALIGN_BITS-1:0] != '0);

    pxs_addr_gen #(.AW(AW), .IW(IW)) u_agen (
        .base    (cmd_base),
        .imm     (cmd_imm),
        .mode    (mode_in),
        .wide    (cmd_wide),
        .ea0     (ea0_c),
        .wb_addr (wb_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ea0_q    <= '0;
            wb_q     <= '0;
            wide_q   <= 1'b0;
            store_q  <= 1'b0;
            fault_q  <= 1'b0;
            has_wb_q <= 1'b0;
            rt0_q    <= '0;
            rt1_q    <= '0;
            wd0_q    <= '0;
            wd1_q    <= '0;
        end else if (accept) begin
            ea0_q    <= ea0_c;
            wb_q     <= wb_c;
            wide_q   <= cmd_wide;
            store_q  <= cmd_store;
            fault_q  <= misaligned;
            has_wb_q <= mode_writes_back(mode_in) && !misaligned;
            rt0_q    <= cmd_rt0;
            rt1_q    <= cmd_rt1;
            wd0_q    <= cmd_wdata0;
            wd1_q    <= cmd_wdata1;
        end
    end

    pxs_beat_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .abort    (misaligned),
        .has_wb   (has_wb_q),
        .mem_ack  (mem_ack),
        .mem_req  (mem_req),
        .beat_sel (beat_sel),
        .busy     (busy),
        .wb_valid (wb_valid),
        .done     (done)
    );

    assign mem_we    = store_q;
    assign mem_wide  = wide_q;
    assign mem_addr  = beat_sel ? ea0_q + (wide_q ? STEP_WIDE : STEP_NARROW) : ea0_q;
    assign mem_wdata = beat_sel ? wd1_q : wd0_q;

    assign ld_valid = mem_req && mem_ack && !store_q;
    assign ld_idx   = beat_sel ? rt1_q : rt0_q;
    assign ld_data  = mem_rdata;

    assign wb_addr  = wb_q;
    assign fault    = done && fault_q;

    p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_wdata) && $stable(mem_we)));

    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && !beat_sel) |=>
            (mem_req && mem_addr == $past(mem_addr) + (mem_wide ? STEP_WIDE : STEP_NARROW)));

    p_fault_no_wb_r9: assert property (@(posedge clk) disable iff (rst)
        fault |-> !$past(wb_valid) && !$past(mem_req));

    p_idle_no_req_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !wb_valid));

endmodule

// File: tb/tb_pair_xfer_seq.sv
module tb_pair_xfer_seq;
    localparam int AW = 16, DW = 64, IW = 7, RW = 5;

    logic          clk = 1'b0;
    logic          rst;
    logic          cmd_valid;
    logic [1:0]    cmd_mode;
    logic          cmd_wide, cmd_store, cmd_sp_base;
    logic [AW-1:0] cmd_base;
    logic [IW-1:0] cmd_imm;
    logic [RW-1:0] cmd_rt0, cmd_rt1;
    logic [DW-1:0] cmd_wdata0, cmd_wdata1;
    logic          busy, mem_req, mem_we, mem_wide, mem_ack;
    logic [AW-1:0] mem_addr, wb_addr;
    logic [DW-1:0] mem_wdata, mem_rdata, ld_data;
    logic          ld_valid, wb_valid, done, fault;
    logic [RW-1:0] ld_idx;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    pair_xfer_seq #(.AW(AW), .DW(DW), .IW(IW), .RW(RW)) dut (.*);

    function automatic logic [DW-1:0] memfn(input logic [AW-1:0] a);
        return {16'hA5C3, a, ~a, 16'h3C5A};
    endfunction

    assign mem_rdata = memfn(mem_addr);

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_cmd(input int mode, input logic wide, input logic store,
                           input logic sp, input logic [AW-1:0] base,
                           input int imm, input int lat, input logic junk);
        logic [AW-1:0] immx, e0, ewb, hold_addr;
        logic [DW-1:0] w0, w1;
        logic [RW-1:0] r0, r1;
        logic exp_fault, exp_wb;
        int nbeats, nwb, wcnt;
        logic seen_done;
        immx = AW'(imm);
        exp_fault = sp && (base[3:0] != 4'd0);
        if (mode == 1)      e0 = base + immx;
        else if (mode == 2) e0 = base;
        else                e0 = base + (wide ? immx * 8 : immx * 4);
        ewb = base + immx;
        exp_wb = (mode == 1 || mode == 2) && !exp_fault;
        r0 = RW'(mode * 7 + 3);
        r1 = RW'(mode * 5 + 17);
        w0 = {32'hDEAD0000 | 32'(imm & 16'hFFFF), 32'(base)};
        w1 = ~w0;

        @(negedge clk);
        cmd_valid = 1'b1; cmd_mode = 2'(mode); cmd_wide = wide; cmd_store = store;
        cmd_sp_base = sp; cmd_base = base; cmd_imm = IW'(imm);
        cmd_rt0 = r0; cmd_rt1 = r1; cmd_wdata0 = w0; cmd_wdata1 = w1;
        @(negedge clk);
        chk(busy == 1'b1, "R1 busy after accept", 64'(busy), 64'd1);
        if (junk) begin
            cmd_base = base ^ 16'h5550; cmd_mode = 2'(2 - mode % 3);
            cmd_rt0 = ~r0; cmd_wdata0 = 64'h1;
        end else begin
            cmd_valid = 1'b0;
        end
        nbeats = 0; nwb = 0; wcnt = 0; seen_done = 1'b0; hold_addr = '0;
        for (int cyc = 0; cyc < 40 && !seen_done; cyc++) begin
            if (cyc > 0) @(negedge clk);
            mem_ack = 1'b0;
            #1;
            if (mem_req) begin
                if (wcnt == 0) hold_addr = mem_addr;
                else chk(mem_addr == hold_addr, "R7 held address", 64'(mem_addr), 64'(hold_addr));
                if (wcnt == lat) begin
                    mem_ack = 1'b1;
                    #1;
                    if (nbeats == 0)
                        chk(mem_addr == e0, "R2/R4/R5/R6 first address", 64'(mem_addr), 64'(e0));
                    else
                        chk(mem_addr == e0 + (wide ? 16'd8 : 16'd4), "R3 second address", 64'(mem_addr), 64'(e0 + (wide ? 16'd8 : 16'd4)));
                    chk(mem_we == store, "R10 write enable", 64'(mem_we), 64'(store));
                    if (store) begin
                        chk(mem_wdata == (nbeats == 0 ? w0 : w1), "R2/R3 store data order", mem_wdata, nbeats == 0 ? w0 : w1);
                        chk(ld_valid == 1'b0, "R10 no load strobe on store", 64'(ld_valid), 64'd0);
                    end else begin
                        chk(ld_valid == 1'b1, "R10 load strobe", 64'(ld_valid), 64'd1);
                        chk(ld_idx == (nbeats == 0 ? r0 : r1), "R10 load index order", 64'(ld_idx), 64'(nbeats == 0 ? r0 : r1));
                        chk(ld_data == memfn(mem_addr), "R10 load data", ld_data, memfn(mem_addr));
                    end
                    nbeats++;
                    wcnt = 0;
                end else begin
                    wcnt++;
                end
            end
            if (wb_valid) begin
                nwb++;
                chk(nbeats == 2, "R8 writeback after both beats", 64'(nbeats), 64'd2);
                chk(wb_addr == ewb, "R5/R6 writeback value", 64'(wb_addr), 64'(ewb));
            end
            if (done) begin
                seen_done = 1'b1;
                cmd_valid = 1'b0;
                chk(fault == exp_fault, "R9 fault flag", 64'(fault), 64'(exp_fault));
            end
        end
        mem_ack = 1'b0;
        chk(seen_done, "R11 done reached", 64'(seen_done), 64'd1);
        chk(nbeats == (exp_fault ? 0 : 2), "R9/R3 beat count", 64'(nbeats), 64'(exp_fault ? 0 : 2));
        chk(nwb == (exp_wb ? 1 : 0), "R4/R8 writeback count", 64'(nwb), 64'(exp_wb ? 1 : 0));
        @(negedge clk);
        chk(!done && !busy, "R11 idle after done", {62'd0, done, busy}, 64'd0);
    endtask

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_mode = '0; cmd_wide = 1'b0; cmd_store = 1'b0;
        cmd_sp_base = 1'b0; cmd_base = '0; cmd_imm = '0; cmd_rt0 = '0; cmd_rt1 = '0;
        cmd_wdata0 = '0; cmd_wdata1 = '0; mem_ack = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && !done && !wb_valid, "R1 reset state",
            {60'd0, busy, mem_req, done, wb_valid}, 64'd0);
        rst = 1'b0;
        for (int m = 0; m < 3; m++)
            for (int w = 0; w < 2; w++)
                for (int s = 0; s < 2; s++)
                    for (int i = 0; i < 2; i++)
                        for (int l = 0; l < 3; l++)
                            run_cmd(m, w[0], s[0], 1'b0, 16'h1230, (i == 0) ? -16 : 3, l, l == 1);
        run_cmd(1, 1'b1, 1'b1, 1'b1, 16'h8000, -16, 1, 1'b0); // R5 aligned push
        run_cmd(2, 1'b1, 1'b0, 1'b1, 16'h7FF0, 16, 0, 1'b0);  // R6 aligned pop
        run_cmd(1, 1'b1, 1'b1, 1'b1, 16'h8004, -16, 0, 1'b0); // R9 misaligned
        run_cmd(2, 1'b0, 1'b0, 1'b1, 16'h7FF8, 16, 2, 1'b1);  // R9 misaligned, junk held
        run_cmd(0, 1'b1, 1'b0, 1'b1, 16'h0000, -1, 0, 1'b0);  // R4 wrap below zero
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule